// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block collects interrupt requests from a parameterized number of sources and picks one winner to offer the CPU. Each source has a small control word holding a pending flag, an enable bit and a two-part priority: a group number and a rank inside that group. A pending flag is set by a hardware event on the source's request line, or by software writing the control word. The winner is offered with its source index, which the CPU uses as its vector number, and with its combined level.

The arbiter registers its choice, so a winner appears one clock after its request becomes pending and enabled. Whenever nothing enabled is pending, the arbiter drops its valid flag and leaves the index and level outputs unchanged. An action request is raised only when the registered winner is still pending and enabled, the global interrupt enable is set, and the winner's level is strictly above the CPU's current level. If the CPU acknowledges while the action request is high, the arbiter clears that source's pending flag at the same clock edge.

Top module: `irq_arbiter`

## Requirements
- R1: Control word layout: bit 0 is the pending flag, bit 1 is the enable, bits 4:2 are the rank inside the group and bits 8:5 are the group. A write replaces the whole word of source `reg_addr`, and `reg_rdata` returns the stored word of that source. After reset every word is 0.
- R2: A high `hw_req[i]` at a clock edge sets the pending flag of source i. This takes precedence over a write or an acknowledge that clears the same flag in that cycle.
- R3: Setting the pending flag through a write makes the source take part in arbitration exactly as a hardware event does.
- R4: `win_valid` rises one clock edge after the edge at which a flag became pending and enabled, not at that same edge.
- R5: The combined level is group*8 + rank, so any higher group beats any rank of a lower group. Sources whose flag or enable is 0 never win.
- R6: Among candidates with equal combined level, the lowest source index wins.
- R7: `act_req` is 1 only when `win_valid` is 1, the winner is still pending and enabled, `glob_ie` is 1 and `win_level` > `cpu_level`. With an equal or higher CPU level, the request is not offered and its flag stays set.
- R8: `cpu_ack` at an edge where `act_req` is 1 clears the winner's pending flag at that edge.
- R9: A write that clears a pending flag drops `act_req` for that source at once, and the next edge recomputes the winner without it.
- R10: When no enabled source is pending, `win_valid` is 0 and `win_idx` and `win_level` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | N_SRC | One hardware request event line per source |
| reg_we | input | 1 | Write strobe for a control word |
| reg_addr | input | IDX_W | Source selected for write and read |
| reg_wdata | input | CTRL_W | Control word to write |
| reg_rdata | output | CTRL_W | Stored control word of the selected source |
| cpu_level | input | LVL_W | Current CPU priority level |
| glob_ie | input | 1 | Global interrupt enable |
| cpu_ack | input | 1 | CPU accepts the offered winner |
| win_valid | output | 1 | A registered winner is present |
| win_idx | output | IDX_W | Winner source index (vector number) |
| win_level | output | LVL_W | Winner combined level |
| act_req | output | 1 | Action request to the CPU |

## Verification
A single pending source shows the one-clock start latency and the action gate. Pairs of sources are then set up with a higher group against a higher rank, with exact ties, and with a disabled source of higher level. These show whether the group really dominates, which index wins a tie, and whether the enable masks a candidate. A burst of simultaneous hardware events, drained by acknowledges, must come out in strictly falling level order with ties taken in index order. This separates a correct priority search from a first-found or last-found scan. CPU levels just below, equal to and above the winner, together with withdraw-by-write and full drain, check the strict comparison, the stale-winner guard and the idle hold.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    // Control word field positions; the level field is {group, rank}
    localparam int FLAG_BIT = 0;
    localparam int EN_BIT   = 1;
    localparam int LVL_LSB  = 2;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 7,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0]            cand,
    input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
    output logic                        any,
    output logic [IDX_W-1:0]            idx,
    output logic [LVL_W-1:0]            level
);
    logic [N_SRC:0] seen;
    logic [IDX_W-1:0] best_i [N_SRC+1];
    logic [LVL_W-1:0] best_l [N_SRC+1];

    assign seen[0]   = 1'b0;
    assign best_i[0] = '0;
    assign best_l[0] = '0;

    // Ascending scan; only a strictly higher level replaces, so ties keep the lower index
    for (genvar g = 0; g < N_SRC; g++) begin : g_scan
        logic take;
        assign take        = cand[g] && (!seen[g] || (lvl[g] > best_l[g]));
        assign seen[g+1]   = seen[g] | cand[g];
        assign best_i[g+1] = take ? IDX_W'(g) : best_i[g];
        assign best_l[g+1] = take ? lvl[g]    : best_l[g];
    end

    assign any   = seen[N_SRC];
    assign idx   = best_i[N_SRC];
    assign level = best_l[N_SRC];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int GRP_W = 4,
    parameter int SUB_W = 3,
    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int LVL_W  = GRP_W + SUB_W,
    localparam int CTRL_W = LVL_LSB + LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  hw_req,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  cpu_level,
    input  logic              glob_ie,
    input  logic              cpu_ack,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx,
    output logic [LVL_W-1:0]  win_level,
    output logic              act_req
);
    typedef struct packed {
        logic [N_SRC-1:0]            flag;
        logic [N_SRC-1:0]            en;
        logic [N_SRC-1:0][LVL_W-1:0] lvl;
        logic                        win_v;
        logic [IDX_W-1:0]            win_i;
        logic [LVL_W-1:0]            win_l;
    } arb_state_t;

    arb_state_t q, d;

    logic [N_SRC-1:0] pend_flags;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [LVL_W-1:0] pick_lvl;
    logic             addr_ok;

    assign pend_flags = q.flag;
    assign addr_ok    = int'(reg_addr) < N_SRC;

    irq_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
        .cand  (q.flag & q.en),
        .lvl   (q.lvl),
        .any   (pick_any),
        .idx   (pick_idx),
        .level (pick_lvl)
    );

    // Offer only a winner that is still pending and enabled right now
    assign act_req = q.win_v && pend_flags[q.win_i] && q.en[q.win_i]
                     && glob_ie && (q.win_l > cpu_level);

    always_comb begin
        d = q;
        if (reg_we && addr_ok) begin
            d.flag[reg_addr] = reg_wdata[FLAG_BIT];
            d.en[reg_addr]   = reg_wdata[EN_BIT];
            d.lvl[reg_addr]  = reg_wdata[CTRL_W-1:LVL_LSB];
        end
        if (cpu_ack && act_req) begin
            d.flag[q.win_i] = 1'b0;
        end
        d.flag  = d.flag | hw_req;
        d.win_v = pick_any;
        if (pick_any) begin
            d.win_i = pick_idx;
            d.win_l = pick_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (addr_ok) begin
            reg_rdata = {q.lvl[reg_addr], q.en[reg_addr], q.flag[reg_addr]};
        end
    end

    assign win_valid = q.win_v;
    assign win_idx   = q.win_i;
    assign win_level = q.win_l;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] hw_req,
    input logic [LVL_W-1:0] cpu_level,
    input logic             glob_ie,
    input logic             cpu_ack,
    input logic             win_valid,
    input logic [IDX_W-1:0] win_idx,
    input logic [LVL_W-1:0] win_level,
    input logic             act_req,
    input logic [N_SRC-1:0] pend
);
    a_r7_offer_gate: assert property (@(posedge clk) disable iff (!rst_n)
        act_req |-> (win_valid && glob_ie && pend[win_idx] && (win_level > cpu_level)));

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_req) |=> ((pend & $past(hw_req)) == $past(hw_req)));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && act_req && !hw_req[win_idx]) |=> !pend[$past(win_idx)]);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid && $past(!win_valid)) |-> ($stable(win_idx) && $stable(win_level)));

    a_r4_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> $past(|pend));
endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_req    (hw_req),
    .cpu_level (cpu_level),
    .glob_ie   (glob_ie),
    .cpu_ack   (cpu_ack),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_level (win_level),
    .act_req   (act_req),
    .pend      (pend_flags)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hw_req = '0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] reg_rdata;
    logic [6:0] cpu_level = '0;
    logic       glob_ie = 1'b0;
    logic       cpu_ack;
    logic       man_ack = 1'b0;
    logic       mon_ack = 1'b0;
    logic       auto_ack = 1'b0;
    logic       win_valid;
    logic [2:0] win_idx;
    logic [6:0] win_level;
    logic       act_req;

    int total = 0;
    int bad = 0;

    typedef struct { int idx; int lvl; } item_t;
    item_t sb_q[$];

    assign cpu_ack = man_ack | mon_ack;

    always #2.5 clk = ~clk;

    irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_level(cpu_level), .glob_ie(glob_ie), .cpu_ack(cpu_ack),
        .win_valid(win_valid), .win_idx(win_idx), .win_level(win_level),
        .act_req(act_req)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [8:0] word(bit f, bit e, int grp, int sub);
        return 9'((grp << 5) | (sub << 2) | (int'(e) << 1) | int'(f));
    endfunction

    task automatic wr(int idx, bit f, bit e, int grp, int sub);
        reg_we    = 1'b1;
        reg_addr  = 3'(idx);
        reg_wdata = word(f, e, grp, sub);
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic expect_take(int idx, int lvl);
        item_t it;
        it.idx = idx;
        it.lvl = lvl;
        sb_q.push_back(it);
    endtask

    // Monitor: acknowledges each offered winner and compares it with the queue head
    always @(negedge clk) begin
        if (auto_ack && act_req) begin
            if (sb_q.size() == 0) begin
                check("R6", "unexpected winner idx", int'(win_idx), -1);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check("R6", "drain order idx", int'(win_idx), it.idx);
                check("R5", "drain order level", int'(win_level), it.lvl);
            end
            mon_ack = 1'b1;
        end else begin
            mon_ack = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] hold_i;
        logic [6:0] hold_l;
        step(4);
        rst_n = 1'b1;
        step(1);
        // reset state
        check("R1", "reset win_valid", int'(win_valid), 0);
        check("R7", "reset act_req", int'(act_req), 0);
        reg_addr = 3'd0;
        #1 check("R1", "reset word", int'(reg_rdata), 0);

        // R1 readback
        wr(2, 0, 1, 3, 5);
        reg_addr = 3'd2;
        #1 check("R1", "readback word", int'(reg_rdata), int'(word(0, 1, 3, 5)));

        // R3/R4: software set, one-clock start
        glob_ie = 1'b1;
        cpu_level = 7'd0;
        wr(2, 1, 1, 3, 0);
        check("R4", "no winner at set edge", int'(win_valid), 0);
        step(1);
        check("R4", "winner next edge", int'(win_valid), 1);
        check("R3", "sw winner idx", int'(win_idx), 2);
        check("R3", "sw winner level", int'(win_level), 24);
        check("R7", "offered when above cpu", int'(act_req), 1);

        // R5: group dominates rank; disabled source ignored
        wr(5, 1, 1, 2, 7);
        wr(1, 1, 0, 7, 7);
        step(2);
        check("R5", "group beats rank", int'(win_idx), 2);
        check("R5", "disabled excluded level", int'(win_level), 24);

        // R6: ties
        wr(6, 1, 1, 3, 0);
        step(2);
        check("R6", "tie keeps lower idx", int'(win_idx), 2);
        wr(0, 1, 1, 3, 0);
        step(2);
        check("R6", "tie takes idx0", int'(win_idx), 0);

        // R7: strict compare and global enable
        cpu_level = 7'd24;
        #1 check("R7", "equal level not offered", int'(act_req), 0);
        step(3);
        reg_addr = 3'd0;
        #1 check("R7", "flag stays pending", int'(reg_rdata[0]), 1);
        cpu_level = 7'd23;
        #1 check("R7", "level below offered", int'(act_req), 1);
        glob_ie = 1'b0;
        #1 check("R7", "global disable blocks", int'(act_req), 0);
        glob_ie = 1'b1;
        cpu_level = 7'd0;

        // R9: withdraw by write
        wr(0, 0, 1, 3, 0);
        check("R9", "withdrawn not offered", int'(act_req), 0);
        step(1);
        check("R9", "winner recomputed", int'(win_idx), 2);
        check("R9", "new winner offered", int'(act_req), 1);

        // R8: acknowledge clears
        man_ack = 1'b1;
        step(1);
        man_ack = 1'b0;
        reg_addr = 3'd2;
        #1 check("R8", "ack cleared flag", int'(reg_rdata[0]), 0);
        check("R8", "no offer after ack", int'(act_req), 0);
        step(1);
        check("R8", "next winner idx", int'(win_idx), 6);

        // R2: hardware event on a disabled source
        hw_req = 8'h10;
        step(1);
        hw_req = '0;
        reg_addr = 3'd4;
        #1 check("R2", "hw event sets flag", int'(reg_rdata[0]), 1);
        step(1);
        check("R5", "disabled hw flag not winner", int'(win_idx), 6);

        // R10: drain by writes, idle hold
        wr(6, 0, 1, 3, 0);
        step(1);
        check("R10", "winner 5 before idle", int'(win_idx), 5);
        wr(5, 0, 1, 2, 7);
        step(1);
        check("R10", "idle valid", int'(win_valid), 0);
        hold_i = win_idx;
        hold_l = win_level;
        check("R10", "held idx", int'(hold_i), 5);
        check("R10", "held level", int'(hold_l), 23);
        step(3);
        check("R10", "idx still held", int'(win_idx), 5);
        check("R10", "level still held", int'(win_level), 23);

        // Scoreboard drain from a burst of hardware events
        for (int i = 0; i < N; i++) wr(i, 0, 0, 0, 0);
        wr(0, 0, 1, 1, 2);
        wr(3, 0, 1, 5, 0);
        wr(4, 0, 1, 5, 0);
        wr(6, 0, 1, 0, 7);
        wr(7, 0, 1, 4, 7);
        expect_take(3, 40);
        expect_take(4, 40);
        expect_take(7, 39);
        expect_take(0, 10);
        expect_take(6, 7);
        auto_ack = 1'b1;
        hw_req = 8'b1101_1001;
        step(1);
        hw_req = '0;
        step(20);
        auto_ack = 1'b0;
        check("R8", "all drained", sb_q.size(), 0);
        check("R10", "idle after drain", int'(win_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule